// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog countdown timer that sits on a simple register bus. A 32-bit down-counter steps once for every cycle in which the tick-enable input is high. The tick is intended to come from a 1 MHz divider, so the longest timeout is about 4295 seconds. Software loads a reload value. The counter takes that value only when a fixed 16-bit key is written to the restart register, so a stray write cannot keep the watchdog alive.

When the counter is enabled and a tick arrives while it holds zero, the block expires. What happens on expiry depends on the control bits:
- a one-cycle reset-request strobe, with a one-hot code that names the reset target;
- a one-cycle strobe for an external pulse shaper;
- a sticky boot-secondary flag.

After expiry the counter reloads and keeps running while it is still enabled. A programmable threshold in the upper control bits raises a sticky pre-timeout interrupt before expiry. Both sticky flags are cleared through a dedicated clear register.

Top module: `wdt_core`

## Requirements
- R1: After synchronous reset, the counter and the reload register both read RELOAD_RST. Control and timeout status read 0. The irq, rst_req, ext_trig, rst_tgt and boot_sel outputs are all 0.
- R2: Writing exactly 32'h0000_4755 to offset 0x08 loads the reload value into the counter at that clock edge. A write of any other value to 0x08 leaves the counter unchanged.
- R3: The counter drops by one at each edge where control bit 0 (enable) is 1 and tick is 1. It holds its value when tick is 0 or when enable is 0, and no expiry event happens while enable is 0.
- R4: An enabled tick with the counter at 0 is an expiry. At that edge the counter reloads. If control bit 1 is set, rst_req is high for exactly the following cycle; if bit 1 is clear, rst_req stays low.
- R5: If control bit 3 is set, ext_trig is high for exactly the one cycle after an expiry.
- R6: While rst_req is high, rst_tgt is one-hot and decodes control bits 6:5: 0 gives 3'b001 (SoC), 1 gives 3'b010 (full chip), 2 gives 3'b100 (CPU only), and 3 is treated as SoC. While rst_req is low, rst_tgt is 0.
- R7: An expiry with control bit 7 set sets timeout-status bit 1. The boot_sel output follows that bit, and it stays set until it is cleared.
- R8: When enable and control bit 2 are both set and the counter equals {ctrl[31:10], 10'b0}, timeout-status bit 2 sets at the next edge. The irq output follows that bit and stays high until cleared. With control bit 2 clear, no interrupt is raised.
- R9: A write to offset 0x14 with bit 0 = 1 clears timeout-status bits 1 and 2. A write there with bit 0 = 0 has no effect.
- R10: Reads return:
  - the live counter at 0x00;
  - the reload value at 0x04;
  - the control register at 0x0C, with bits 9:8 always 0;
  - timeout status at 0x10, where only bits 2 and 1 are used.

  Reads of 0x08, 0x14 and every other offset return 0. Writes to undefined offsets change nothing.
- R11: A valid restart write in the same cycle as an expiring tick takes priority. The counter loads the reload value and no expiry strobe is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one pulse per microsecond |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Sticky pre-timeout interrupt |
| rst_req | output | 1 | One-cycle reset request on expiry |
| ext_trig | output | 1 | One-cycle trigger for an external pulse shaper |
| rst_tgt | output | 3 | One-hot reset target while rst_req is high |
| boot_sel | output | 1 | Sticky boot-secondary selection |

## Verification
The hardest situation to reach is the pre-timeout threshold, because it only exists at multiples of 1024 counts. The bench loads a reload value of 2000 and sets the threshold field to 1. It then steps exactly 976 ticks, so that the counter sits on the threshold while irq is still low, and checks that irq rises one cycle later. The restart-versus-expiry race needs a valid key write placed in the same cycle as a tick while the counter holds zero. The bench arranges this by loading a zero reload, restarting, and then issuing the key write with tick raised. All four reset-mode codes are swept through full expiries, with the expected target code and external strobe computed from the mode number.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DW      = 32;
    localparam int THR_LSB = 10;
    localparam int THR_W   = DW - THR_LSB;

    localparam logic [DW-1:0] RESTART_KEY = 32'h0000_4755;
    localparam logic [DW-1:0] CTRL_WMASK  = 32'hFFFF_FCFF;

    localparam int OFF_COUNT   = 'h00;
    localparam int OFF_RELOAD  = 'h04;
    localparam int OFF_RESTART = 'h08;
    localparam int OFF_CTRL    = 'h0C;
    localparam int OFF_STATUS  = 'h10;
    localparam int OFF_CLEAR   = 'h14;

    typedef enum logic [1:0] {
        TGT_SOC  = 2'd0,
        TGT_CHIP = 2'd1,
        TGT_CPU  = 2'd2,
        TGT_RSVD = 2'd3
    } tgt_mode_e;

    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic [1:0]       rsvd;
        logic             boot_sec;
        logic [1:0]       mode;
        logic             clk_sel;
        logic             ext_en;
        logic             irq_en;
        logic             rst_en;
        logic             run;
    } wdt_ctrl_t;

    typedef struct packed {
        logic irq_flag;
        logic boot_flag;
    } wdt_stat_t;

    function automatic logic [2:0] tgt_onehot(logic [1:0] m);
        case (tgt_mode_e'(m))
            TGT_CHIP: return 3'b010;
            TGT_CPU:  return 3'b100;
            default:  return 3'b001;
        endcase
    endfunction

    function automatic logic [DW-1:0] thr_value(wdt_ctrl_t c);
        return {c.thr, {THR_LSB{1'b0}}};
    endfunction

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter logic [DW-1:0] RELOAD_RST = 32'h0000_FFFF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          run,
    input  logic          irq_en,
    input  logic          restart,
    input  logic [DW-1:0] reload,
    input  logic [DW-1:0] thr,
    output logic [DW-1:0] cnt,
    output logic          expire,
    output logic          pre_hit
);

    logic step;

    assign step    = run && tick;
    assign expire  = step && !restart && (cnt == '0);
    assign pre_hit = run && irq_en && (cnt == thr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= RELOAD_RST;
        end else if (restart) begin
            cnt <= reload;
        end else if (step) begin
            cnt <= (cnt == '0) ? reload : cnt - 1'b1;
        end
    end

    AST_RESTART_LOADS: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == $past(reload))) else $error("restart load"); // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!restart && !step) |=> $stable(cnt)) else $error("counter moved"); // R3

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (step && !restart && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)) else $error("step"); // R3

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int            ADDR_W     = 8,
    parameter logic [DW-1:0] RELOAD_RST = 32'h0000_FFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     cnt,
    input  logic              expire,
    input  logic              pre_hit,
    output logic [DW-1:0]     bus_rdata,
    output logic [DW-1:0]     reload,
    output wdt_ctrl_t         ctrl,
    output wdt_stat_t         stat,
    output logic              restart
);

    logic hit_reload, hit_ctrl, clr_hit;

    assign hit_reload = bus_we && (bus_addr == ADDR_W'(OFF_RELOAD));
    assign hit_ctrl   = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
    assign restart    = bus_we && (bus_addr == ADDR_W'(OFF_RESTART))
                        && (bus_wdata == RESTART_KEY);
    assign clr_hit    = bus_we && (bus_addr == ADDR_W'(OFF_CLEAR)) && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            reload <= RELOAD_RST;
            ctrl   <= '0;
            stat   <= '0;
        end else begin
            if (hit_reload) reload <= bus_wdata;
            if (hit_ctrl)   ctrl   <= wdt_ctrl_t'(bus_wdata & CTRL_WMASK);
            stat.boot_flag <= (stat.boot_flag && !clr_hit) || (expire && ctrl.boot_sec);
            stat.irq_flag  <= (stat.irq_flag && !clr_hit) || pre_hit;
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_W'(OFF_COUNT):  bus_rdata = cnt;
            ADDR_W'(OFF_RELOAD): bus_rdata = reload;
            ADDR_W'(OFF_CTRL):   bus_rdata = ctrl;
            ADDR_W'(OFF_STATUS): bus_rdata = {{(DW-3){1'b0}}, stat.irq_flag, stat.boot_flag, 1'b0};
            default:             bus_rdata = '0;
        endcase
    end

    AST_BOOT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat.boot_flag && !clr_hit) |=> stat.boot_flag) else $error("boot lost"); // R7

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat.irq_flag && !clr_hit) |=> stat.irq_flag) else $error("irq lost"); // R8

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (clr_hit && !pre_hit && !expire) |=> (!stat.irq_flag && !stat.boot_flag)) else $error("clear"); // R9

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int            ADDR_W     = 8,
    parameter logic [31:0]   RELOAD_RST = 32'h0000_FFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              rst_req,
    output logic              ext_trig,
    output logic [2:0]        rst_tgt,
    output logic              boot_sel
);

    logic [DW-1:0] cnt, reload;
    wdt_ctrl_t     ctrl;
    wdt_stat_t     stat;
    logic          restart, expire, pre_hit;

    wdt_regs #(.ADDR_W(ADDR_W), .RELOAD_RST(RELOAD_RST)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt       (cnt),
        .expire    (expire),
        .pre_hit   (pre_hit),
        .bus_rdata (bus_rdata),
        .reload    (reload),
        .ctrl      (ctrl),
        .stat      (stat),
        .restart   (restart)
    );

    wdt_counter #(.RELOAD_RST(RELOAD_RST)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .run     (ctrl.run),
        .irq_en  (ctrl.irq_en),
        .restart (restart),
        .reload  (reload),
        .thr     (thr_value(ctrl)),
        .cnt     (cnt),
        .expire  (expire),
        .pre_hit (pre_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req  <= 1'b0;
            ext_trig <= 1'b0;
            rst_tgt  <= '0;
        end else begin
            rst_req  <= expire && ctrl.rst_en;
            ext_trig <= expire && ctrl.ext_en;
            rst_tgt  <= (expire && ctrl.rst_en) ? tgt_onehot(ctrl.mode) : 3'b000;
        end
    end

    assign irq      = stat.irq_flag;
    assign boot_sel = stat.boot_flag;

    AST_TGT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $onehot(rst_tgt)) else $error("target code"); // R6

    AST_TGT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rst_req |-> (rst_tgt == 3'b000)) else $error("target idle"); // R6

    AST_STROBE_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> ($past(ctrl.run) && $past(tick))) else $error("spurious reset"); // R4

endmodule

// File: tb/sim_wdt_core.sv
module sim_wdt_core;

    logic        clk = 1'b0;
    logic        rst;
    logic        tick;
    logic        bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq, rst_req, ext_trig, boot_sel;
    logic [2:0]  rst_tgt;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    wdt_core #(.ADDR_W(8), .RELOAD_RST(32'h0000_0100)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req),
        .ext_trig(ext_trig), .rst_tgt(rst_tgt), .boot_sel(boot_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic t = 1'b0);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; tick = t;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = '0; tick = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 8'h00;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; tick = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v); chk("R1 counter", v, 32'h100);
        rd(8'h04, v); chk("R1 reload", v, 32'h100);
        rd(8'h0C, v); chk("R1 ctrl", v, 0);
        rd(8'h10, v); chk("R1 status", v, 0);
        chk("R1 outputs", {irq, rst_req, ext_trig, rst_tgt, boot_sel}, 0);

        // R2 keyed restart
        wr(8'h04, 32'd20);
        wr(8'h08, 32'h0000_4756);
        rd(8'h00, v); chk("R2 wrong key ignored", v, 32'h100);
        wr(8'h08, 32'h0001_4755);
        rd(8'h00, v); chk("R2 upper bits break key", v, 32'h100);
        wr(8'h08, 32'h0000_4755);
        rd(8'h00, v); chk("R2 key loads", v, 20);

        // R3 count, hold on no tick, hold while disabled
        wr(8'h0C, 32'h1);
        ticks(5);
        rd(8'h00, v); chk("R3 decrement", v, 15);
        repeat (3) @(negedge clk);
        rd(8'h00, v); chk("R3 no tick hold", v, 15);
        wr(8'h0C, 32'h0);
        ticks(4);
        rd(8'h00, v); chk("R3 disabled hold", v, 15);

        // R4 R5 R6 R7 expiry sweep over reset modes
        for (int m = 0; m < 4; m++) begin
            logic [31:0] c;
            logic [2:0]  et;
            c  = 32'h3 | (32'(m & 1) << 3) | (32'(m) << 5) | ((m >= 2) ? 32'h80 : 32'h0);
            et = (m == 1) ? 3'b010 : (m == 2) ? 3'b100 : 3'b001;
            wr(8'h04, 32'd3);
            wr(8'h0C, c);
            wr(8'h08, 32'h0000_4755);
            ticks(3);
            chk("R4 no strobe before expiry", {31'b0, rst_req}, 0);
            ticks(1);
            chk("R4 strobe", {31'b0, rst_req}, 1);
            chk("R6 target", {29'b0, rst_tgt}, {29'b0, et});
            chk("R5 ext trigger", {31'b0, ext_trig}, 32'(m & 1));
            chk("R7 boot flag", {31'b0, boot_sel}, (m >= 2) ? 1 : 0);
            rd(8'h00, v); chk("R4 reload after expiry", v, 3);
            @(negedge clk);
            chk("R4 single cycle", {26'b0, rst_req, ext_trig, rst_tgt, 1'b0}, 0);
        end
        rd(8'h10, v); chk("R7 status bit1", v, 32'h2);

        // R4 reset disabled
        wr(8'h0C, 32'h1);
        wr(8'h08, 32'h0000_4755);
        ticks(4);
        chk("R4 no strobe without bit1", {28'b0, rst_req, rst_tgt}, 0);
        rd(8'h00, v); chk("R4 continue after expiry", v, 3);

        // R9 clear register
        wr(8'h14, 32'h0);
        chk("R9 bit0 zero ignored", {31'b0, boot_sel}, 1);
        wr(8'h14, 32'h1);
        chk("R9 clear boot", {31'b0, boot_sel}, 0);
        rd(8'h10, v); chk("R9 status cleared", v, 0);

        // R8 pre-timeout at threshold 1024
        wr(8'h04, 32'd2000);
        wr(8'h0C, 32'h0000_0405);
        wr(8'h08, 32'h0000_4755);
        ticks(976);
        rd(8'h00, v); chk("R8 at threshold", v, 1024);
        chk("R8 irq not yet", {31'b0, irq}, 0);
        @(negedge clk);
        chk("R8 irq raised", {31'b0, irq}, 1);
        rd(8'h10, v); chk("R8 status bit2", v, 32'h4);
        ticks(10);
        chk("R8 irq sticky", {31'b0, irq}, 1);
        wr(8'h14, 32'h1);
        chk("R9 clear irq", {31'b0, irq}, 0);

        // R8 interrupt disabled
        wr(8'h0C, 32'h0000_0401);
        wr(8'h08, 32'h0000_4755);
        ticks(980);
        chk("R8 no irq when bit2 clear", {31'b0, irq}, 0);

        // R11 restart beats expiry
        wr(8'h0C, 32'h0000_0003);
        wr(8'h04, 32'd0);
        wr(8'h08, 32'h0000_4755);
        wr(8'h04, 32'd5);
        wr(8'h08, 32'h0000_4755, 1'b1);
        chk("R11 no strobe", {31'b0, rst_req}, 0);
        rd(8'h00, v); chk("R11 reload wins", v, 5);

        // R10 read map and undefined offsets
        wr(8'h0C, 32'h0);
        rd(8'h08, v); chk("R10 restart reads zero", v, 0);
        rd(8'h14, v); chk("R10 clear reads zero", v, 0);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, v); chk("R10 undefined reads zero", v, 0);
        rd(8'h04, v); chk("R10 reload untouched", v, 5);
        rd(8'h0C, v); chk("R10 ctrl untouched", v, 0);
        wr(8'h0C, 32'hFFFF_FF00);
        rd(8'h0C, v); chk("R10 ctrl reserved bits", v, 32'hFFFF_FC00);
        wr(8'h0C, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule